// File: doc/BRIEF.md
# Scan-Test Core Clock Source Controller

This block sits beside a JTAG test access port and chooses which clock a processor core receives while scan patterns are applied through the port. It holds a full 16-state TAP controller, a 4-bit instruction register and a 4-bit chain-select register. It drives two clock enables toward the core: one for the functional clock and one for the debug (test) clock. Both clocks are modelled as enables clocked by TCK.

Test mode is never entered on its own. An external sequencer raises `test_req`, and the block accepts it only while the functional clock request is held low. While test mode is active, the core receives one debug-clock enable per TCK cycle the TAP spends in Run-Test/Idle, but only if chain 0 is selected and INTEST is the current instruction. To leave, the sequencer drops `test_req` and loads BYPASS. Only then does the functional clock come back. If the functional request is raised during test mode while BYPASS is not loaded, a sticky error flag is set.

Top module: `tcs_clock_switch`

## Requirements
- R1: While `trst_n` is low, the TAP goes to Test-Logic-Reset, the instruction becomes BYPASS (1111), the chain select becomes 0, and `test_active`, `func_clk_en`, `dbg_clk_en` and `hs_err` are all low.
- R2: Outside test mode, `func_clk_en` follows `func_clk_req` one TCK edge later, and `dbg_clk_en` stays low.
- R3: `test_active` sets on a TCK edge at which `test_req` is 1 and `func_clk_req` is 0. It never sets while `func_clk_req` is 1.
- R4: For each TCK edge at which test mode is active, the TAP is in Run-Test/Idle, the instruction is INTEST (1100) and the chain select is 0, `dbg_clk_en` is high for the following cycle. A stay of K extra cycles in Run-Test/Idle therefore gives K+1 pulses.
- R5: No debug-clock pulse occurs under any other instruction code, including EXTEST (0000), under any chain select other than 0, or in any TAP state other than Run-Test/Idle.
- R6: The instruction register is 4 bits wide and shifted LSB first. It updates in Update-IR. Test-Logic-Reset forces it to BYPASS.
- R7: While SCAN_N (0010) is current, Update-DR loads the 4-bit chain select shifted LSB first. Test-Logic-Reset returns the chain select to 0.
- R8: Test mode stays active while any code other than BYPASS is current. It clears on an edge where `test_req` is 0 and BYPASS is current. `func_clk_en` can return only on the edge after that.
- R9: `func_clk_en` and `dbg_clk_en` are never high together, and a switch from one to the other always passes through at least one cycle with both low.
- R10: `hs_err` sets on the first edge at which `func_clk_req` is seen high after being seen low, provided test mode is active and BYPASS is not current. Once set, it stays high until `trst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state advances on its rising edge |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | TAP mode select |
| tdi | input | 1 | Serial data into the selected shift register |
| tdo | output | 1 | Serial data out of the selected shift register |
| test_req | input | 1 | Sequencer request to enter (1) or leave (0) test mode |
| func_clk_req | input | 1 | Request for the functional core clock |
| func_clk_en | output | 1 | Functional clock enable toward the core |
| dbg_clk_en | output | 1 | Debug clock enable toward the core, one pulse per qualifying cycle |
| test_active | output | 1 | Test mode is in force |
| hs_err | output | 1 | Sticky flag for a functional request made during test mode |

## Verification
A debug-clock pulse and a handshake violation can occur on the same TCK edge. This happens when the functional request rises while the TAP idles in Run-Test/Idle under INTEST with chain 0. The bench provokes it by raising `func_clk_req` in the middle of an idle window. It then checks three things: the pulse count over the window still equals the number of idle edges, `hs_err` sets, and `func_clk_en` stays low throughout. The same arithmetic count is applied in a sweep over all 16 instruction codes and three chain-select values.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  localparam int unsigned OPW = 4;
  localparam logic [OPW-1:0] OPC_EXTEST = 4'b0000;
  localparam logic [OPW-1:0] OPC_SCAN_N = 4'b0010;
  localparam logic [OPW-1:0] OPC_INTEST = 4'b1100;
  localparam logic [OPW-1:0] OPC_BYPASS = 4'b1111;

  function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  return m ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  return m ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

endpackage

// File: rtl/tcs_tap.sv
module tcs_tap
  import tcs_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_e state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= tap_next(state, tms);
  end

endmodule

// File: rtl/tcs_regs.sv
module tcs_regs
  import tcs_pkg::*;
#(
  parameter int unsigned IR_W = 4,
  parameter int unsigned SEL_W = 4,
  parameter logic [IR_W-1:0] OP_BYPASS = 4'b1111,
  parameter logic [IR_W-1:0] OP_SCAN_N = 4'b0010
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  tap_st_e          state,
  output logic [IR_W-1:0]  ir_q,
  output logic [SEL_W-1:0] chain_q,
  output logic             tdo
);

  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

  logic [IR_W-1:0]  ir_sh;
  logic [SEL_W-1:0] sel_sh;
  logic             byp_q;
  logic             scan_sel;

  assign scan_sel = (ir_q == OP_SCAN_N);

  // Instruction path
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= '0;
      ir_q  <= OP_BYPASS;
    end else begin
      case (state)
        ST_TLR:    ir_q  <= OP_BYPASS;
        ST_CAP_IR: ir_sh <= IR_CAPTURE;
        ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        ST_UPD_IR: ir_q  <= ir_sh;
        default:   ;
      endcase
    end
  end

  // Data path: chain select register or one-bit bypass
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sel_sh  <= '0;
      chain_q <= '0;
      byp_q   <= 1'b0;
    end else begin
      case (state)
        ST_TLR: chain_q <= '0;
        ST_CAP_DR: begin
          sel_sh <= chain_q;
          byp_q  <= 1'b0;
        end
        ST_SH_DR: begin
          if (scan_sel) sel_sh <= {tdi, sel_sh[SEL_W-1:1]};
          else          byp_q  <= tdi;
        end
        ST_UPD_DR: if (scan_sel) chain_q <= sel_sh;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_SH_IR: tdo = ir_sh[0];
      ST_SH_DR: tdo = scan_sel ? sel_sh[0] : byp_q;
      default:  tdo = 1'b0;
    endcase
  end

endmodule

// File: rtl/tcs_clk_ctl.sv
module tcs_clk_ctl
  import tcs_pkg::*;
#(
  parameter int unsigned IR_W = 4,
  parameter int unsigned SEL_W = 4,
  parameter logic [IR_W-1:0] OP_INTEST = 4'b1100,
  parameter logic [IR_W-1:0] OP_BYPASS = 4'b1111,
  parameter int unsigned DBG_CHAIN = 0
) (
  input  logic             tck,
  input  logic             trst_n,
  input  tap_st_e          state,
  input  logic [IR_W-1:0]  ir_q,
  input  logic [SEL_W-1:0] chain_q,
  input  logic             test_req,
  input  logic             func_clk_req,
  output logic             func_clk_en,
  output logic             dbg_clk_en,
  output logic             test_active,
  output logic             hs_err
);

  localparam logic [SEL_W-1:0] PULSE_CHAIN = SEL_W'(DBG_CHAIN);

  logic req_q;
  logic in_bypass;
  logic enter_ok;
  logic leave_ok;
  logic test_d;
  logic dbg_d;
  logic func_d;
  logic viol;

  assign in_bypass = (ir_q == OP_BYPASS);
  assign enter_ok  = test_req && !func_clk_req;
  assign leave_ok  = !test_req && in_bypass;
  assign test_d    = test_active ? !leave_ok : enter_ok;

  assign dbg_d  = test_active && (state == ST_RTI) && (ir_q == OP_INTEST)
                  && (chain_q == PULSE_CHAIN) && !func_clk_en;
  assign func_d = !test_active && func_clk_req && !dbg_clk_en;
  assign viol   = test_active && func_clk_req && !req_q && !in_bypass;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      req_q       <= 1'b0;
      test_active <= 1'b0;
      dbg_clk_en  <= 1'b0;
      func_clk_en <= 1'b0;
      hs_err      <= 1'b0;
    end else begin
      req_q       <= func_clk_req;
      test_active <= test_d;
      dbg_clk_en  <= dbg_d;
      func_clk_en <= func_d;
      hs_err      <= hs_err | viol;
    end
  end

endmodule

// File: rtl/tcs_clock_switch.sv
module tcs_clock_switch
  import tcs_pkg::*;
#(
  parameter int unsigned IR_W = OPW,
  parameter int unsigned SEL_W = 4,
  parameter logic [IR_W-1:0] OP_SCAN_N = OPC_SCAN_N,
  parameter logic [IR_W-1:0] OP_INTEST = OPC_INTEST,
  parameter logic [IR_W-1:0] OP_BYPASS = OPC_BYPASS,
  parameter int unsigned DBG_CHAIN = 0
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  input  logic test_req,
  input  logic func_clk_req,
  output logic func_clk_en,
  output logic dbg_clk_en,
  output logic test_active,
  output logic hs_err
);

  tap_st_e          tap_state;
  logic [IR_W-1:0]  ir_q;
  logic [SEL_W-1:0] chain_q;

  tcs_tap u_tap (
    .tck   (tck),
    .trst_n(trst_n),
    .tms   (tms),
    .state (tap_state)
  );

  tcs_regs #(
    .IR_W(IR_W), .SEL_W(SEL_W), .OP_BYPASS(OP_BYPASS), .OP_SCAN_N(OP_SCAN_N)
  ) u_regs (
    .tck    (tck),
    .trst_n (trst_n),
    .tdi    (tdi),
    .state  (tap_state),
    .ir_q   (ir_q),
    .chain_q(chain_q),
    .tdo    (tdo)
  );

  tcs_clk_ctl #(
    .IR_W(IR_W), .SEL_W(SEL_W), .OP_INTEST(OP_INTEST),
    .OP_BYPASS(OP_BYPASS), .DBG_CHAIN(DBG_CHAIN)
  ) u_ctl (
    .tck         (tck),
    .trst_n      (trst_n),
    .state       (tap_state),
    .ir_q        (ir_q),
    .chain_q     (chain_q),
    .test_req    (test_req),
    .func_clk_req(func_clk_req),
    .func_clk_en (func_clk_en),
    .dbg_clk_en  (dbg_clk_en),
    .test_active (test_active),
    .hs_err      (hs_err)
  );

endmodule

// File: rtl/tcs_clock_switch_chk.sv
module tcs_clock_switch_chk
  import tcs_pkg::*;
#(
  parameter int unsigned IR_W = 4,
  parameter int unsigned SEL_W = 4,
  parameter logic [IR_W-1:0] OP_INTEST = 4'b1100,
  parameter logic [IR_W-1:0] OP_BYPASS = 4'b1111,
  parameter int unsigned DBG_CHAIN = 0
) (
  input logic             tck,
  input logic             trst_n,
  input logic             test_req,
  input logic             func_clk_req,
  input logic             func_clk_en,
  input logic             dbg_clk_en,
  input logic             test_active,
  input logic             hs_err,
  input tap_st_e          tap_state,
  input logic [IR_W-1:0]  ir_q,
  input logic [SEL_W-1:0] chain_q
);

  // R9
  clk_mutex_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !(func_clk_en && dbg_clk_en));

  // R9
  dbg_to_func_gap_chk: assert property (@(posedge tck) disable iff (!trst_n)
    dbg_clk_en |=> !func_clk_en);

  // R9
  func_to_dbg_gap_chk: assert property (@(posedge tck) disable iff (!trst_n)
    func_clk_en |=> !dbg_clk_en);

  // R4
  dbg_qualified_chk: assert property (@(posedge tck) disable iff (!trst_n)
    dbg_clk_en |-> (test_active && $past(tap_state) == ST_RTI
                    && $past(ir_q) == OP_INTEST
                    && $past(chain_q) == SEL_W'(DBG_CHAIN)));

  // R3
  entry_handshake_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(test_active) |-> ($past(test_req) && !$past(func_clk_req)));

  // R8
  exit_bypass_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $fell(test_active) |-> ($past(ir_q) == OP_BYPASS && !$past(test_req)));

  // R2
  func_outside_test_chk: assert property (@(posedge tck) disable iff (!trst_n)
    func_clk_en |-> (!$past(test_active) && $past(func_clk_req)));

  // R10
  err_sticky_chk: assert property (@(posedge tck) disable iff (!trst_n)
    hs_err |=> hs_err);

endmodule

bind tcs_clock_switch tcs_clock_switch_chk #(
  .IR_W(IR_W), .SEL_W(SEL_W), .OP_INTEST(OP_INTEST),
  .OP_BYPASS(OP_BYPASS), .DBG_CHAIN(DBG_CHAIN)
) i_chk (
  .tck         (tck),
  .trst_n      (trst_n),
  .test_req    (test_req),
  .func_clk_req(func_clk_req),
  .func_clk_en (func_clk_en),
  .dbg_clk_en  (dbg_clk_en),
  .test_active (test_active),
  .hs_err      (hs_err),
  .tap_state   (tap_state),
  .ir_q        (ir_q),
  .chain_q     (chain_q)
);

// File: tb/test_tcs_clock_switch.sv
`timescale 1ns/1ps
module test_tcs_clock_switch;

  localparam logic [3:0] C_SCAN_N = 4'b0010;
  localparam logic [3:0] C_INTEST = 4'b1100;
  localparam logic [3:0] C_BYPASS = 4'b1111;

  logic tck = 1'b0;
  logic trst_n, tms, tdi, tdo, test_req, func_clk_req;
  logic func_clk_en, dbg_clk_en, test_active, hs_err;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int overlaps = 0;
  logic prev_dbg = 1'b0;
  logic prev_func = 1'b0;

  always #4 tck = ~tck;

  tcs_clock_switch i_tcs_clock_switch (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .test_req(test_req), .func_clk_req(func_clk_req),
    .func_clk_en(func_clk_en), .dbg_clk_en(dbg_clk_en),
    .test_active(test_active), .hs_err(hs_err)
  );

  // Pulse counter and enable-overlap monitor, sampled 2 ns after each rising edge
  always @(posedge tck) begin
    #2;
    if (dbg_clk_en) pulses++;
    if (dbg_clk_en && func_clk_en) overlaps++;
    if (func_clk_en && prev_dbg) overlaps++;
    if (dbg_clk_en && prev_func) overlaps++;
    prev_dbg  = dbg_clk_en;
    prev_func = func_clk_en;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d = 1'b0);
    tms = m;
    tdi = d;
    @(negedge tck);
  endtask

  // From Run-Test/Idle, back to Run-Test/Idle
  task automatic load_ir(input logic [3:0] v);
    step(1); step(1); step(0); step(0);
    for (int i = 0; i < 4; i++) step(i == 3, v[i]);
    step(1); step(0);
  endtask

  task automatic load_dr4(input logic [3:0] v);
    step(1); step(0); step(0);
    for (int i = 0; i < 4; i++) step(i == 3, v[i]);
    step(1); step(0);
  endtask

  // K idle cycles plus the leaving edge, then an empty DR pass back to idle
  task automatic window(input int k, input int raise_at);
    pulses = 0;
    for (int i = 0; i < k; i++) begin
      if (i == raise_at) func_clk_req = 1'b1;
      step(0);
    end
    step(1); step(0); step(1); step(1); step(0);
  endtask

  task automatic pulse_reset;
    trst_n = 1'b0;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    test_req = 1'b0; func_clk_req = 1'b0;
    repeat (3) @(negedge tck);
    // R1 reset state
    check("R1 test_active in reset", test_active, 0);
    check("R1 func_clk_en in reset", func_clk_en, 0);
    check("R1 dbg_clk_en in reset", dbg_clk_en, 0);
    check("R1 hs_err in reset", hs_err, 0);
    trst_n = 1'b1;
    step(0);

    // R2 functional clock follows the request outside test mode
    func_clk_req = 1'b1;
    step(0);
    check("R2 func_clk_en follows request", func_clk_en, 1);
    check("R2 dbg_clk_en low outside test", dbg_clk_en, 0);
    func_clk_req = 1'b0;
    step(0);
    check("R2 func_clk_en drops with request", func_clk_en, 0);

    // R3 entry is refused while the functional request is high
    func_clk_req = 1'b1;
    step(0);
    test_req = 1'b1;
    step(0); step(0); step(0);
    check("R3 no entry with func_clk_req high", test_active, 0);
    func_clk_req = 1'b0;
    step(0);
    check("R3 entry after request drops", test_active, 1);
    check("R3 func_clk_en off at entry", func_clk_en, 0);

    // R5 BYPASS after reset gives no pulses
    window(3, -1);
    check("R5 no pulses under BYPASS", pulses, 0);

    // R4 R5 R7 sweep: every code against chains 0, 1 and 8
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 3; s++) begin
        logic [3:0] ch;
        int exp;
        ch = (s == 0) ? 4'd0 : ((s == 1) ? 4'd1 : 4'd8);
        load_ir(C_SCAN_N);
        load_dr4(ch);
        load_ir(4'(c));
        window(2, -1);
        exp = (4'(c) == C_INTEST && ch == 4'd0) ? 3 : 0;
        check($sformatf("R4/R5 code=%0d chain=%0d pulses", c, ch), pulses, exp);
      end
    end

    // R4 window arithmetic for chain 0 under INTEST
    load_ir(C_SCAN_N);
    load_dr4(4'd0);
    load_ir(C_INTEST);
    window(0, -1);
    check("R4 zero extra idle gives one pulse", pulses, 1);
    window(5, -1);
    check("R4 five extra idle gives six pulses", pulses, 6);

    // R6 Test-Logic-Reset forces BYPASS
    step(1); step(1); step(1); step(1); step(1);
    step(0);
    window(2, -1);
    check("R6 BYPASS after Test-Logic-Reset", pulses, 0);
    check("R6 test mode kept through TAP reset", test_active, 1);

    // R10 with R4: functional request rises inside an idle window under INTEST
    load_ir(C_INTEST);
    window(6, 2);
    check("R4 pulses continue during violation", pulses, 7);
    check("R10 hs_err set by request under INTEST", hs_err, 1);
    check("R9 func_clk_en held off in test", func_clk_en, 0);
    func_clk_req = 1'b0;
    step(0); step(0);
    check("R10 hs_err sticky", hs_err, 1);

    // R8 no exit without BYPASS
    test_req = 1'b0;
    func_clk_req = 1'b1;
    step(0); step(0); step(0);
    check("R8 test kept while INTEST current", test_active, 1);
    check("R8 func_clk_en off before BYPASS", func_clk_en, 0);
    load_ir(C_BYPASS);
    step(0);
    check("R8 exit after BYPASS", test_active, 0);
    check("R8 func_clk_en not yet back", func_clk_en, 0);
    step(0);
    check("R8 func_clk_en resumes", func_clk_en, 1);

    // R1 asynchronous reset clears the sticky flag
    pulse_reset();
    check("R1 hs_err cleared by reset", hs_err, 0);
    check("R1 test_active cleared by reset", test_active, 0);

    // R10 no error when BYPASS is current
    func_clk_req = 1'b0;
    test_req = 1'b1;
    step(0); step(0);
    check("R3 re-entry", test_active, 1);
    func_clk_req = 1'b1;
    step(0); step(0);
    check("R10 no error under BYPASS", hs_err, 0);
    check("R9 func_clk_en off while test active", func_clk_en, 0);
    test_req = 1'b0;
    step(0); step(0); step(0);
    check("R8 exit with BYPASS already current", test_active, 0);
    check("R2 functional clock back", func_clk_en, 1);

    check("R9 enable overlap or missing gap events", overlaps, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule